// File: doc/BRIEF.md
# Segment Display RAM Writer

This block holds the display memory of a small segment LCD controller: one 4-bit entry per segment, one bit of each entry per common line. A command parser in front of it delivers two kinds of request: an address load, which places the write pointer, and display-data bytes. Each byte is broken into two nibbles that land in two neighbouring entries. The pointer moves one entry per nibble and wraps from the last segment back to the first.

Both nibbles of a byte are committed in the clock cycle the byte is offered. No later acknowledge is awaited. A registered read port serves the scan logic, which can fetch the four common bits of any segment with one cycle of latency.

Top module: `seg_ram_writer`

## Requirements
- R1: While reset is high, and after it is released, every entry reads back as 0 and the read output is 0.
- R2: The read output presents the entry addressed by `rd_addr` on the clock edge after the address is applied.
- R3: A pulse of `set_en` loads the write pointer with `set_addr` reduced modulo 36 (for example 40 becomes 4 and 63 becomes 27).
- R4: Within a data byte, bits 7, 6, 5 and 4 are stored as COM0, COM1, COM2 and COM3 (entry bits 0 to 3) of the entry at the pointer. Bits 3, 2, 1 and 0 are stored as COM0 to COM3 of the following entry.
- R5: Every nibble written advances the pointer by one, so every byte advances it by two, and back-to-back bytes continue without a gap.
- R6: The entry after 0x23 is 0x00. A byte that starts at 0x23 writes its second nibble to 0x00, and a byte that starts at 0x22 leaves the pointer at 0x00. The pointer never holds a value above 0x23.
- R7: Both nibbles of a byte are written on the edge at which `wr_en` is sampled high. A read issued in the following cycle returns them.
- R8: When `set_en` and `wr_en` are high in the same cycle, the byte is written starting at the newly loaded address.
- R9: A read of an entry in the same cycle that this entry is written returns the old contents. The next read returns the new contents.
- R10: A read address of 36 or above returns 0.
- R11: A write changes only its two target entries. All other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_en | input | 1 | Load the write pointer |
| set_addr | input | 6 | Pointer value to load, reduced modulo 36 |
| wr_en | input | 1 | Display-data byte valid |
| wr_byte | input | 8 | Display-data byte, upper nibble stored first |
| rd_addr | input | 6 | Segment address for the scan read |
| rd_data | output | 4 | COM0..COM3 bits of the addressed segment, registered |

## Verification
Two activities can meet in one cycle. A scan read can hit the entry being written, and a pointer load can coincide with a data byte. The bench sets up the read collision by driving `rd_addr` to the current write pointer, or to the pointer plus one, in the same cycle as `wr_en`. It expects the pre-write contents there and the new contents one cycle later. For the second case it raises `set_en` and `wr_en` together, including with an out-of-range load value. It then reads back the entries the reduced load address selects, and the entries the stale pointer would have selected.

// File: rtl/seg_ram_pkg.sv
package seg_ram_pkg;

    localparam int COM_COUNT = 4;
    localparam int SEG_COUNT = 36;
    localparam int BYTE_W    = 2 * COM_COUNT;

    typedef logic [COM_COUNT-1:0] com_bits_t;

    typedef struct packed {
        com_bits_t first;
        com_bits_t second;
    } nib_pair_t;

    typedef enum logic [1:0] {
        PTR_HOLD,
        PTR_LOAD,
        PTR_STEP
    } ptr_op_e;

    function automatic com_bits_t msb_first_to_com(input com_bits_t n);
        com_bits_t r;
        for (int i = 0; i < COM_COUNT; i++) begin
            r[i] = n[COM_COUNT-1-i];
        end
        return r;
    endfunction

    function automatic nib_pair_t split_byte(input logic [BYTE_W-1:0] b);
        nib_pair_t p;
        p.first  = msb_first_to_com(b[BYTE_W-1 -: COM_COUNT]);
        p.second = msb_first_to_com(b[COM_COUNT-1:0]);
        return p;
    endfunction

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
    import seg_ram_pkg::*;
#(
    parameter int SEGS = SEG_COUNT,
    parameter int AW   = $clog2(SEGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [AW-1:0] set_addr,
    input  logic          wr_en,
    output logic [AW-1:0] wa0,
    output logic [AW-1:0] wa1,
    output logic [AW-1:0] ptr_q
);

    localparam logic [AW-1:0] LAST = AW'(SEGS - 1);

    function automatic logic [AW-1:0] next_idx(input logic [AW-1:0] a);
        return (a == LAST) ? '0 : a + 1'b1;
    endfunction

    logic [AW-1:0] loaded;
    logic [AW-1:0] base;
    logic [AW-1:0] ptr_d;
    ptr_op_e       op;

    always_comb begin
        loaded = AW'(int'(set_addr) % SEGS);
        base   = set_en ? loaded : ptr_q;
        if (wr_en)       op = PTR_STEP;
        else if (set_en) op = PTR_LOAD;
        else             op = PTR_HOLD;
    end

    assign wa0 = base;
    assign wa1 = next_idx(base);

    always_comb begin
        unique case (op)
            PTR_STEP: ptr_d = next_idx(wa1);
            PTR_LOAD: ptr_d = loaded;
            default:  ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

endmodule

// File: rtl/seg_nibble_split.sv
module seg_nibble_split
    import seg_ram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [AW-1:0]     a_first,
    input  logic [AW-1:0]     a_second,
    output logic              we,
    output logic [AW-1:0]     wa0,
    output com_bits_t         wd0,
    output logic [AW-1:0]     wa1,
    output com_bits_t         wd1
);

    nib_pair_t pair;

    always_comb begin
        pair = split_byte(wr_byte);
        we   = wr_en;
        wa0  = a_first;
        wd0  = pair.first;
        wa1  = a_second;
        wd1  = pair.second;
    end

endmodule

// File: rtl/seg_ram_array.sv
module seg_ram_array
    import seg_ram_pkg::*;
#(
    parameter int SEGS = SEG_COUNT,
    parameter int AW   = $clog2(SEGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa0,
    input  com_bits_t     wd0,
    input  logic [AW-1:0] wa1,
    input  com_bits_t     wd1,
    input  logic [AW-1:0] rd_addr,
    output com_bits_t     rd_data
);

    com_bits_t mem [SEGS];
    com_bits_t rd_sel;

    for (genvar g = 0; g < SEGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (we && wa0 == AW'(g)) begin
                mem[g] <= wd0;
            end else if (we && wa1 == AW'(g)) begin
                mem[g] <= wd1;
            end
        end
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < SEGS; i++) begin
            if (rd_addr == AW'(i)) rd_sel = mem[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_sel;
    end

endmodule

// File: rtl/seg_ram_writer.sv
module seg_ram_writer
    import seg_ram_pkg::*;
#(
    parameter int SEGS = SEG_COUNT,
    parameter int AW   = $clog2(SEGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_en,
    input  logic [AW-1:0]        set_addr,
    input  logic                 wr_en,
    input  logic [BYTE_W-1:0]    wr_byte,
    input  logic [AW-1:0]        rd_addr,
    output logic [COM_COUNT-1:0] rd_data
);

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] a_first;
    logic [AW-1:0] a_second;
    logic          we;
    logic [AW-1:0] wa0;
    logic [AW-1:0] wa1;
    com_bits_t     wd0;
    com_bits_t     wd1;

    seg_addr_ctrl #(.SEGS(SEGS), .AW(AW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .set_en   (set_en),
        .set_addr (set_addr),
        .wr_en    (wr_en),
        .wa0      (a_first),
        .wa1      (a_second),
        .ptr_q    (ptr_q)
    );

    seg_nibble_split #(.AW(AW)) u_split (
        .wr_en    (wr_en),
        .wr_byte  (wr_byte),
        .a_first  (a_first),
        .a_second (a_second),
        .we       (we),
        .wa0      (wa0),
        .wd0      (wd0),
        .wa1      (wa1),
        .wd1      (wd1)
    );

    seg_ram_array #(.SEGS(SEGS), .AW(AW)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .wa0     (wa0),
        .wd0     (wd0),
        .wa1     (wa1),
        .wd1     (wd1),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/seg_ram_writer_chk.sv
module seg_ram_writer_chk #(
    parameter int SEGS = 36,
    parameter int AW   = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          set_en,
    input logic [AW-1:0] set_addr,
    input logic          wr_en,
    input logic [AW-1:0] rd_addr,
    input logic [3:0]    rd_data,
    input logic [AW-1:0] ptr
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> rd_data == 4'h0);

    a_r10_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) >= SEGS) |=> rd_data == 4'h0);

    a_r3_load_reduced: assert property (@(posedge clk) disable iff (rst)
        (set_en && !wr_en) |=> int'(ptr) == int'($past(set_addr)) % SEGS);

    a_r8_load_then_step: assert property (@(posedge clk) disable iff (rst)
        (set_en && wr_en) |=> int'(ptr) == (int'($past(set_addr)) % SEGS + 2) % SEGS);

    a_r5_step_two: assert property (@(posedge clk) disable iff (rst)
        (!set_en && wr_en) |=> int'(ptr) == (int'($past(ptr)) + 2) % SEGS);

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !wr_en) |=> $stable(ptr));

    a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < SEGS);

endmodule

bind seg_ram_writer seg_ram_writer_chk #(.SEGS(SEGS), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .set_en   (set_en),
    .set_addr (set_addr),
    .wr_en    (wr_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ptr      (ptr_q)
);

// File: tb/test_seg_ram_writer.sv
module test_seg_ram_writer;

    localparam int SEGS = 36;
    localparam int AW   = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          set_en = 1'b0;
    logic [AW-1:0] set_addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_byte = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [3:0]    rd_data;

    always #10 clk = ~clk;

    seg_ram_writer i_seg_ram_writer (
        .clk      (clk),
        .rst      (rst),
        .set_en   (set_en),
        .set_addr (set_addr),
        .wr_en    (wr_en),
        .wr_byte  (wr_byte),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    typedef struct {
        logic [3:0] data;
        int         addr;
        string      req;
    } exp_t;

    exp_t       q[$];
    logic [3:0] model [SEGS];
    int         mptr = 0;
    int         checks = 0;
    int         fails = 0;
    bit         rd_issue = 1'b0;
    bit         done = 1'b0;

    function automatic logic [3:0] to_com(input logic [3:0] n);
        return {n[0], n[1], n[2], n[3]};
    endfunction

    task automatic report(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input bit s_en, input int s_addr, input bit w_en,
                        input logic [7:0] b, input bit r_en, input int r_addr,
                        input string req);
        exp_t e;
        @(negedge clk);
        set_en   = s_en;
        set_addr = AW'(s_addr);
        wr_en    = w_en;
        wr_byte  = b;
        rd_addr  = AW'(r_addr);
        rd_issue = r_en;
        if (r_en) begin
            e.data = (r_addr < SEGS) ? model[r_addr] : 4'h0;
            e.addr = r_addr;
            e.req  = req;
            q.push_back(e);
        end
        if (s_en) mptr = s_addr % SEGS;
        if (w_en) begin
            model[mptr]              = to_com(b[7:4]);
            model[(mptr + 1) % SEGS] = to_com(b[3:0]);
            mptr = (mptr + 2) % SEGS;
        end
    endtask

    task automatic rd(input int a, input string req);
        step(1'b0, 0, 1'b0, 8'h00, 1'b1, a, req);
    endtask

    task automatic wb(input logic [7:0] b);
        step(1'b0, 0, 1'b1, b, 1'b0, 0, "");
    endtask

    task automatic setp(input int a);
        step(1'b1, a, 1'b0, 8'h00, 1'b0, 0, "");
    endtask

    initial begin : monitor
        exp_t e;
        bit   pend;
        forever begin
            @(posedge clk);
            pend = rd_issue;
            #5;
            if (pend) begin
                if (q.size() == 0) begin
                    report(1'b0, "R2 queue", 0, 1);
                end else begin
                    e = q.pop_front();
                    report(rd_data === e.data, e.req, int'(rd_data), int'(e.data));
                end
            end
        end
    end

    initial begin : watchdog
        #4_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        logic [15:0] lfsr;
        for (int i = 0; i < SEGS; i++) model[i] = 4'h0;
        repeat (3) @(negedge clk);
        report(rd_data === 4'h0, "R1 in reset", int'(rd_data), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: all entries clear after reset; R10: out-of-range reads
        for (int a = 0; a < SEGS; a++) rd(a, "R1");
        rd(36, "R10");
        rd(63, "R10");

        // R3, R4, R7: load pointer, write, read back next cycle
        setp(5);
        wb(8'hA5);
        rd(5, "R4 first nibble");
        rd(6, "R4 second nibble");
        wb(8'h1E);
        rd(7, "R7");
        rd(8, "R7");

        // R5: back-to-back bytes
        wb(8'h37);
        wb(8'hC9);
        wb(8'h64);
        for (int a = 9; a < 15; a++) rd(a, "R5");

        // R6: wrap at the last segment
        setp(34);
        wb(8'h3C);
        wb(8'h81);
        rd(34, "R6");
        rd(35, "R6");
        rd(0, "R6 wrapped");
        rd(1, "R6 wrapped");
        setp(35);
        wb(8'hF0);
        rd(35, "R6");
        rd(0, "R6 split byte");

        // R3: modulo reduction of load value
        setp(40);
        wb(8'h5A);
        rd(4, "R3 mod 36");
        rd(5, "R3 mod 36");
        setp(63);
        wb(8'hB2);
        rd(27, "R3 mod 36");
        rd(28, "R3 mod 36");

        // R8: load and write in the same cycle
        setp(10);
        step(1'b1, 20, 1'b1, 8'hD7, 1'b0, 0, "");
        rd(20, "R8 new address");
        rd(21, "R8 new address");
        rd(10, "R8 stale address untouched");
        step(1'b1, 50, 1'b1, 8'h9E, 1'b0, 0, "");
        rd(14, "R8 reduced");
        rd(15, "R8 reduced");

        // R9: read collides with write
        setp(2);
        step(1'b0, 0, 1'b1, 8'h4B, 1'b1, 2, "R9 old data");
        rd(2, "R9 new data");
        step(1'b0, 0, 1'b1, 8'hE1, 1'b1, 5, "R9 old data second nibble");
        rd(5, "R9 new data second nibble");

        // R5: pseudo-random traffic
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0] == 4'h0, int'(lfsr[15:10]), lfsr[4] | lfsr[5],
                 lfsr[13:6], 1'b1, int'(lfsr[11:6]), "R5 random");
        end

        // R11: full sweep, every entry matches the model
        for (int a = 0; a < SEGS; a++) rd(a, "R11");

        step(1'b0, 0, 1'b0, 8'h00, 1'b0, 0, "");
        repeat (2) @(negedge clk);
        report(q.size() == 0, "R2 all reads answered", q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule